// File: doc/BRIEF.md
# Six-Stage Pipeline Occupancy and Flush Controller

This block tracks which instructions sit in each of six pipeline stages: fetch, decode, effective-address calculation, operand read, execute and result write. Each stage holds a valid bit and the instruction's program-counter tag. All six stage registers move together, one stage per clock, unless a global stall freezes them. The block keeps its own fetch program counter. A new tag enters the fetch stage whenever the instruction source offers one, the pipeline is not stalled and no interrupt is waiting.

When the execute stage resolves a conditional branch as taken, the block squashes the four younger stages behind it. The branch itself goes on to the write stage, and fetch restarts at the target in the same cycle. An interrupt request stops new admissions, lets the instructions in flight drain out, and is acknowledged only once every stage is empty. Architectural state therefore sits on an exact instruction boundary. A free-running cycle counter and a retirement counter let a user measure fill latency and branch penalty. No datapath, operand storage or register file is modelled.

Top module: `pipe6_flow_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `stage_valid` is 0, `retire_valid`, `redirect_valid` and `irq_ack` are 0, both counters are 0 and `fetch_pc` equals parameter `RESET_PC`.
- R2: Bit i of `stage_valid` reports stage i: bit 0 is fetch, bit 1 decode, bit 2 address calculation, bit 3 operand read, bit 4 execute and bit 5 write. When `src_valid` is high, `stall` is low and no interrupt is pending, the tag `fetch_pc` enters fetch at the clock edge and `fetch_pc` then increments by one. An admitted tag moves up exactly one stage per unstalled clock.
- R3: `retire_valid` pulses for one cycle, with `retire_tag` equal to the instruction's tag, on the first cycle that instruction occupies the write stage. Starting from an empty pipeline, the first of n back-to-back admissions retires 6 cycles after the cycle in which it was offered, and the last retires 6+n-1 cycles after that cycle.
- R4: A branch resolved not taken (`br_resolve` high, `br_taken` low) removes nothing and costs no cycle: the retirement stream stays gap-free.
- R5: A taken branch (`br_resolve` and `br_taken` high, execute stage valid, no stall) clears stages 1 to 4 at the edge. The branch moves into the write stage and `br_target` is admitted into fetch in the same edge. The target then retires 5 cycles after the branch.
- R6: `redirect_valid` is high for exactly the one cycle after a taken resolution, with `redirect_pc` equal to the target.
- R7: While `stall` is high, every stage register holds its value, nothing is admitted, `retire_valid` is 0 from the next cycle, and any branch resolution is ignored.
- R8: From the cycle `irq_req` is seen, admissions stop. `irq_ack` is high for one cycle: the first cycle in which `stage_valid` is 0. Admission resumes in that acknowledge cycle.
- R9: If a taken branch and `irq_req` arrive in the same cycle, the squash and redirect happen first and the target is not admitted. After the acknowledge, fetch resumes at the branch target.
- R10: `cycle_cnt` increments by one on every clock after reset. `retire_cnt` increments by exactly one for each `retire_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Instruction source offers the tag at `fetch_pc` |
| stall | input | 1 | Freeze all stage registers |
| br_resolve | input | 1 | Execute-stage branch resolves this cycle |
| br_taken | input | 1 | Resolved branch is taken |
| br_target | input | PC_W | Branch target tag |
| irq_req | input | 1 | Interrupt request (pulse or level) |
| fetch_pc | output | PC_W | Tag to be admitted next |
| stage_valid | output | 6 | Per-stage occupancy, bit 0 fetch to bit 5 write |
| retire_valid | output | 1 | Retirement strobe |
| retire_tag | output | PC_W | Tag held in the write stage |
| redirect_valid | output | 1 | Fetch was redirected on the previous edge |
| redirect_pc | output | PC_W | Redirect target |
| irq_ack | output | 1 | Pipeline drained, interrupt may be serviced |
| cycle_cnt | output | CNT_W | Clocks since reset |
| retire_cnt | output | CNT_W | Retired instructions since reset |

## Verification
The bench measures fill timing from an empty pipeline. A controller with one register too many or too few on the stage chain would retire at 5 or 7 cycles rather than 6, and finish nine instructions in other than 14. It fires a taken branch with the pipe full and expects the four squashed tags never to retire and the target to follow the branch by exactly 5 cycles. A design that squashed the branch itself, or let a younger tag through, breaks the scoreboard order. A stall carrying a branch resolution must move nothing and squash nothing. An interrupt is aimed at a full pipe and then at the same cycle as a taken branch, which catches an acknowledge that comes early or late, a fetch that keeps admitting while draining, or an arbitration that loses the redirect.

// File: rtl/pipe6_pkg.sv
`timescale 1ns/1ps
package pipe6_pkg;
  localparam int unsigned N_STAGES = 6;
  // stage positions; squash and retire decisions depend on this ordering
  localparam int unsigned ST_FETCH  = 0;
  localparam int unsigned ST_DECODE = 1;
  localparam int unsigned ST_ADDR   = 2;
  localparam int unsigned ST_OPRD   = 3;
  localparam int unsigned ST_EXEC   = 4;
  localparam int unsigned ST_WRITE  = 5;
endpackage

// File: rtl/pipe6_stage_reg.sv
`timescale 1ns/1ps
module pipe6_stage_reg #(
  parameter int unsigned TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             kill,
  input  logic             d_valid,
  input  logic [TAG_W-1:0] d_tag,
  output logic             q_valid,
  output logic [TAG_W-1:0] q_tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_tag   <= '0;
    end else if (!hold) begin
      q_valid <= d_valid & ~kill;
      q_tag   <= d_tag;
    end
  end
endmodule

// File: rtl/pipe6_fetch_pc.sv
`timescale 1ns/1ps
module pipe6_fetch_pc #(
  parameter int unsigned PC_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            block,
  input  logic            src_valid,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic            admit,
  output logic [PC_W-1:0] admit_tag,
  output logic [PC_W-1:0] pc_q
);
  always_comb begin
    admit     = src_valid & ~hold & ~block;
    admit_tag = redirect ? target : pc_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= RESET_PC;
    else if (hold)     pc_q <= pc_q;
    else if (admit)    pc_q <= admit_tag + PC_W'(1);
    else if (redirect) pc_q <= target;
  end
endmodule

// File: rtl/pipe6_irq_drain.sv
`timescale 1ns/1ps
module pipe6_irq_drain (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic empty_next,
  output logic block,
  output logic ack
);
  logic pend_q;
  logic pend_eff;
  logic ack_n;

  always_comb begin
    pend_eff = pend_q | req;
    block    = pend_eff;
    ack_n    = pend_eff & empty_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ack    <= 1'b0;
    end else begin
      pend_q <= pend_eff & ~ack_n;
      ack    <= ack_n;
    end
  end
endmodule

// File: rtl/pipe6_flow_ctrl.sv
`timescale 1ns/1ps
module pipe6_flow_ctrl
  import pipe6_pkg::*;
#(
  parameter int unsigned PC_W     = 16,
  parameter int unsigned CNT_W    = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                src_valid,
  input  logic                stall,
  input  logic                br_resolve,
  input  logic                br_taken,
  input  logic [PC_W-1:0]     br_target,
  input  logic                irq_req,
  output logic [PC_W-1:0]     fetch_pc,
  output logic [N_STAGES-1:0] stage_valid,
  output logic                retire_valid,
  output logic [PC_W-1:0]     retire_tag,
  output logic                redirect_valid,
  output logic [PC_W-1:0]     redirect_pc,
  output logic                irq_ack,
  output logic [CNT_W-1:0]    cycle_cnt,
  output logic [CNT_W-1:0]    retire_cnt
);
  localparam int unsigned NS = N_STAGES;
  localparam int unsigned EX = ST_EXEC;
  localparam int unsigned WB = ST_WRITE;

  logic [NS-1:0]   v_q, d_v, kill;
  logic [PC_W-1:0] tag_q [NS];
  logic [PC_W-1:0] d_tag [NS];
  logic            taken, admit, block, empty_next;
  logic [PC_W-1:0] admit_tag;

  // a resolution only counts when a real instruction sits in execute and the pipe moves
  assign taken = br_resolve & br_taken & v_q[EX] & ~stall;

  pipe6_fetch_pc #(.PC_W(PC_W), .RESET_PC(RESET_PC)) fetch_i (
    .clk(clk), .rst(rst), .hold(stall), .block(block), .src_valid(src_valid),
    .redirect(taken), .target(br_target), .admit(admit), .admit_tag(admit_tag),
    .pc_q(fetch_pc)
  );

  always_comb begin
    d_v[0]   = admit;
    d_tag[0] = admit_tag;
    for (int i = 1; i < NS; i++) begin
      d_v[i]   = v_q[i-1];
      d_tag[i] = tag_q[i-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NS; g++) begin : g_stage
      if (g >= 1 && g <= EX) begin : g_younger
        assign kill[g] = taken;
      end else begin : g_keep
        assign kill[g] = 1'b0;
      end
      pipe6_stage_reg #(.TAG_W(PC_W)) reg_i (
        .clk(clk), .rst(rst), .hold(stall), .kill(kill[g]),
        .d_valid(d_v[g]), .d_tag(d_tag[g]),
        .q_valid(v_q[g]), .q_tag(tag_q[g])
      );
    end
  endgenerate

  assign empty_next = stall ? (v_q == '0) : ((d_v & ~kill) == '0);

  pipe6_irq_drain irq_i (
    .clk(clk), .rst(rst), .req(irq_req), .empty_next(empty_next),
    .block(block), .ack(irq_ack)
  );

  assign stage_valid = v_q;
  assign retire_tag  = tag_q[WB];

  always_ff @(posedge clk) begin
    if (rst) begin
      retire_valid   <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      cycle_cnt      <= '0;
      retire_cnt     <= '0;
    end else begin
      retire_valid   <= ~stall & v_q[WB-1];
      redirect_valid <= taken;
      if (taken) redirect_pc <= br_target;
      cycle_cnt      <= cycle_cnt + CNT_W'(1);
      if (~stall & v_q[WB-1]) retire_cnt <= retire_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pipe6_flow_ctrl_chk.sv
`timescale 1ns/1ps
module pipe6_flow_ctrl_chk
  import pipe6_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                stall,
  input logic [N_STAGES-1:0] stage_valid,
  input logic                retire_valid,
  input logic                redirect_valid,
  input logic                irq_ack,
  input logic [CNT_W-1:0]    retire_cnt
);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(stage_valid));

  assert_stall_noretire_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> !retire_valid);

  assert_retire_in_write_R3: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> stage_valid[ST_WRITE]);

  assert_squash_younger_R5: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (stage_valid[ST_EXEC:ST_DECODE] == '0));

  assert_ack_when_empty_R8: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (stage_valid == '0));

  assert_retire_count_R10: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> (retire_cnt - $past(retire_cnt) == CNT_W'(1)));

  assert_retire_count_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !retire_valid |-> $stable(retire_cnt));
endmodule

bind pipe6_flow_ctrl pipe6_flow_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .stall(stall), .stage_valid(stage_valid),
  .retire_valid(retire_valid), .redirect_valid(redirect_valid),
  .irq_ack(irq_ack), .retire_cnt(retire_cnt)
);

// File: tb/pipe6_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module pipe6_flow_ctrl_tb_top;
  localparam int unsigned PC_W  = 16;
  localparam int unsigned CNT_W = 32;
  localparam logic [PC_W-1:0] RST_PC = 16'h0040;
  localparam real CLK_P = 5.0;
  localparam int WD_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_valid = 0, stall = 0, br_resolve = 0, br_taken = 0, irq_req = 0;
  logic [PC_W-1:0] br_target = '0;
  logic [PC_W-1:0] fetch_pc, retire_tag, redirect_pc;
  logic [5:0] stage_valid;
  logic retire_valid, redirect_valid, irq_ack;
  logic [CNT_W-1:0] cycle_cnt, retire_cnt;

  always #(CLK_P/2) clk = ~clk;

  pipe6_flow_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W), .RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst(rst), .src_valid(src_valid), .stall(stall),
    .br_resolve(br_resolve), .br_taken(br_taken), .br_target(br_target),
    .irq_req(irq_req), .fetch_pc(fetch_pc), .stage_valid(stage_valid),
    .retire_valid(retire_valid), .retire_tag(retire_tag),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .irq_ack(irq_ack), .cycle_cnt(cycle_cnt), .retire_cnt(retire_cnt)
  );

  int checks = 0, failures = 0, total_ret = 0;
  logic [PC_W-1:0] exp_q [$];
  logic [PC_W-1:0] ret_tags [$];
  int              ret_cycs [$];
  logic [PC_W-1:0] pc_m = RST_PC;
  bit pend_m = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected retirements in order
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst && retire_valid) begin
        total_ret++;
        ret_tags.push_back(retire_tag);
        ret_cycs.push_back(int'(cycle_cnt));
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R3 actual=%0h expected=none (unexpected retire)", retire_tag);
        end else begin
          logic [PC_W-1:0] e;
          e = exp_q.pop_front();
          if (e !== retire_tag) begin
            failures++;
            $display("FAIL R3 retire order actual=%0h expected=%0h", retire_tag, e);
          end
        end
      end
    end
  end

  // driver: one call per cycle, models admissions and squashes
  task automatic drive(bit src, bit st, bit brr, bit brt, logic [PC_W-1:0] tgt, bit irq);
    bit tk, blk, adm;
    logic [PC_W-1:0] t;
    @(negedge clk);
    if (irq_ack) pend_m = 0;
    src_valid = src; stall = st; br_resolve = brr; br_taken = brt;
    br_target = tgt; irq_req = irq;
    tk = brr && brt && !st;
    if (tk) for (int k = 0; k < 4; k++) void'(exp_q.pop_back());
    blk = pend_m || irq;
    if (irq) pend_m = 1;
    adm = src && !st && !blk;
    t = tk ? tgt : pc_m;
    if (adm) begin exp_q.push_back(t); pc_m = t + 1'b1; end
    else if (tk) pc_m = tgt;
  endtask

  task automatic stream(int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0, '0, 0);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, '0, 0);
  endtask

  function automatic int cyc_of(logic [PC_W-1:0] tag);
    for (int i = 0; i < ret_tags.size(); i++) if (ret_tags[i] == tag) return ret_cycs[i];
    return -1000;
  endfunction

  task automatic clear_log();
    ret_tags.delete(); ret_cycs.delete();
  endtask

  initial begin
    #(CLK_P * WD_CYC);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0;
    logic [PC_W-1:0] base;
    logic [5:0] sv0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    #0;
    chk("R1 stage_valid", stage_valid, 0);
    chk("R1 retire_valid", retire_valid, 0);
    chk("R1 irq_ack", irq_ack, 0);
    chk("R1 redirect_valid", redirect_valid, 0);
    chk("R1 retire_cnt", retire_cnt, 0);
    chk("R1 fetch_pc", fetch_pc, RST_PC);

    // R2/R3: fill timing, nine back-to-back
    clear_log();
    drive(1, 0, 0, 0, '0, 0);
    c0 = int'(cycle_cnt);
    stream(5);
    drive(1, 0, 0, 0, '0, 0);
    chk("R2 full pipe", stage_valid, 6'h3f);
    stream(2);
    idle(8);
    chk("R3 first retire", ret_cycs[0] - c0, 6);
    chk("R3 ninth retire", ret_cycs[8] - c0, 14);
    chk("R2 fetch_pc advanced", fetch_pc, RST_PC + 9);

    // R10: cycle counter
    c0 = int'(cycle_cnt);
    idle(10);
    chk("R10 cycle_cnt", int'(cycle_cnt) - c0, 10);

    // R4: not-taken branch costs nothing
    clear_log();
    stream(7);
    drive(1, 0, 1, 0, 16'h0333, 0);
    drive(1, 0, 0, 0, '0, 0);
    chk("R4 no redirect", redirect_valid, 0);
    stream(3);
    idle(8);
    chk("R4 count", ret_tags.size(), 12);
    chk("R4 gap-free", ret_cycs[11] - ret_cycs[0], 11);

    // R5/R6: taken branch squashes four younger, target follows
    clear_log();
    base = pc_m;
    stream(7);
    drive(1, 0, 1, 1, 16'h0100, 0);
    drive(1, 0, 0, 0, '0, 0);
    chk("R5 stage_valid after squash", stage_valid, 6'h21);
    chk("R6 redirect_valid", redirect_valid, 1);
    chk("R6 redirect_pc", redirect_pc, 16'h0100);
    drive(1, 0, 0, 0, '0, 0);
    chk("R6 redirect pulse", redirect_valid, 0);
    stream(2);
    idle(8);
    chk("R5 penalty", cyc_of(16'h0100) - cyc_of(base + 2), 5);

    // R7: stall freezes, branch during stall ignored
    clear_log();
    drive(1, 0, 0, 0, '0, 0);
    c0 = int'(cycle_cnt);
    stream(5);
    drive(1, 1, 1, 1, 16'h0300, 0);
    sv0 = stage_valid;
    drive(1, 1, 1, 1, 16'h0300, 0);
    chk("R7 no retire in stall", retire_valid, 0);
    drive(1, 1, 1, 1, 16'h0300, 0);
    chk("R7 no retire in stall", retire_valid, 0);
    drive(1, 0, 0, 0, '0, 0);
    chk("R7 stage_valid held", stage_valid, sv0);
    chk("R7 branch ignored", redirect_valid, 0);
    stream(2);
    idle(8);
    chk("R7 count", ret_tags.size(), 9);
    chk("R7 delayed by stall", ret_cycs[8] - c0, 17);

    // R8: interrupt drains full pipe
    stream(8);
    drive(1, 0, 0, 0, '0, 1);
    drive(1, 0, 0, 0, '0, 0);
    chk("R8 admission stopped", stage_valid, 6'h3e);
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 0, '0, 0);
    chk("R8 no early ack", irq_ack, 0);
    drive(1, 0, 0, 0, '0, 0);
    chk("R8 ack", irq_ack, 1);
    chk("R8 empty at ack", stage_valid, 0);
    drive(0, 0, 0, 0, '0, 0);
    chk("R8 ack one cycle", irq_ack, 0);
    chk("R8 fetch resumed", stage_valid, 6'h01);
    idle(8);

    // R9: taken branch and interrupt together
    clear_log();
    stream(7);
    drive(1, 0, 1, 1, 16'h0200, 1);
    drive(1, 0, 0, 0, '0, 0);
    chk("R9 squash first", stage_valid, 6'h20);
    chk("R9 redirect_pc", redirect_pc, 16'h0200);
    chk("R9 no early ack", irq_ack, 0);
    drive(1, 0, 0, 0, '0, 0);
    chk("R9 ack", irq_ack, 1);
    stream(2);
    idle(8);
    chk("R9 resume at target", ret_tags[ret_tags.size()-3], 16'h0200);

    chk("R10 retire_cnt", retire_cnt, total_ret);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule